// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is a purely combinational 8-bit arithmetic logic unit for a small processor datapath. Each cycle it takes an opcode, two operands and the current status byte. It returns a result byte, a flag saying whether that result should be written back, and the next status byte. Immediate forms of instructions use the same opcodes as their register forms: the decoder simply places the immediate constant on operand `b_i`.

The status byte holds, from bit 7 down to bit 0: global interrupt enable, a user bit, half carry, sign, overflow, negative, zero and carry. Every operation carries its own update mask. Flags outside the mask pass through from `flags_i` to `flags_o` unchanged. Wherever the sign bit is updated it is computed as negative XOR overflow.

Top module: `alu8_flags`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. The opcodes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 logical shift right, 12 rotate right through carry, 13 rotate left through carry, 14 arithmetic shift right, 15 nibble swap, 16 compare, 17 compare with carry, 18 flag set, 19 flag clear and 20 logical shift left.
- R2: Add and subtract, with or without carry, write the 8-bit result and update C, Z, N, V, S and H. C is the carry or borrow out of bit 7, H is the carry or borrow out of bit 3, and V is signed overflow.
- R3: AND, OR and XOR write the result, update Z, N and S, and force V to 0. C, H, T and I are kept.
- R4: One's complement writes 0xFF minus a_i, sets C to 1 and clears V, and updates Z, N and S. Negate writes 0x00 minus a_i, sets C when a_i is nonzero, sets H when the low nibble of a_i is nonzero, sets V only for a_i = 0x80, and updates Z, N and S.
- R5: Increment and decrement write a_i plus or minus 1 and update Z, N, V and S. V is set for increment of 0x7F and for decrement of 0x80. C is kept.
- R6: The three right shifts move bits 7..1 down one place and put bit 0 into C. The top bit becomes 0 (logical), the old C (rotate) or the old bit 7 (arithmetic). Z, N, V and S are updated, with V = N XOR C.
- R7: The two left shifts move bits 6..0 up one place, put bit 7 into C and bit 3 into H, and fill bit 0 with the old C (rotate) or 0 (logical). Z, N, V and S are updated, with V = N XOR C.
- R8: Nibble swap writes {a_i[3:0], a_i[7:4]} and leaves all eight flags unchanged.
- R9: The compares compute a_i minus b_i (minus C for the carry form) and update C, Z, N, V, S and H exactly as subtract does, with wr_en_o at 0.
- R10: For subtract with carry and compare with carry, Z becomes 1 only when the result is zero and the incoming Z was 1. Otherwise Z becomes 0.
- R11: Flag set and flag clear force the flag selected by b_i[2:0] to 1 or to 0, keep the other seven flags, and hold wr_en_o at 0.
- R12: S equals N XOR V after every operation that updates S. Opcodes 21 to 31 hold wr_en_o at 0 and pass flags_i through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (R1) |
| a_i | input | 8 | First operand, also the destination value |
| b_i | input | 8 | Second operand or immediate; bits 2..0 select a flag for set/clear |
| flags_i | input | 8 | Current status byte |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 8 | Next status byte |

## Verification
The block has no registers, so all three outputs are due in the same cycle the inputs are applied. The bench drives a new vector one nanosecond after a rising clock edge and compares the outputs at the following falling edge, by which time the combinational paths have settled. Every opcode is swept over all 256 values of a_i. Each sweep uses eight b_i values whose low three bits cover every flag index, and two incoming status bytes, one with C and Z clear and one with them set. The expected values come from integer arithmetic in the bench.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic [4:0] op_i,
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic [7:0] flags_i,
  output logic [7:0] res_o,
  output logic       wr_en_o,
  output logic [7:0] flags_o
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7;
  localparam logic [4:0] OP_NEG = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSR = 5'd11;
  localparam logic [4:0] OP_ROR = 5'd12, OP_ROL = 5'd13, OP_ASR = 5'd14, OP_SWP = 5'd15;
  localparam logic [4:0] OP_CP  = 5'd16, OP_CPC = 5'd17, OP_FST = 5'd18, OP_FCL = 5'd19;
  localparam logic [4:0] OP_LSL = 5'd20;

  logic [8:0] t;
  logic [7:0] x, y, r, upd, comp, nf;
  logic       cin, c, h, v, z, wr, chain;

  always_comb begin
    t = 9'd0; x = a_i; y = b_i; r = a_i; cin = 1'b0;
    c = flags_i[0]; h = flags_i[5]; v = flags_i[3];
    upd = 8'h00; wr = 1'b1; chain = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        cin = (op_i == OP_ADC) & flags_i[0];
        t = {1'b0, x} + {1'b0, y} + {8'd0, cin};
        r = t[7:0]; c = t[8];
        h = (x[3] & y[3]) | (y[3] & ~r[3]) | (~r[3] & x[3]);
        v = (x[7] == y[7]) && (r[7] != x[7]);
        upd = 8'h3F;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        if (op_i == OP_NEG) begin x = 8'h00; y = a_i; end
        chain = (op_i == OP_SBC) || (op_i == OP_CPC);
        cin = chain & flags_i[0];
        t = {1'b0, x} - {1'b0, y} - {8'd0, cin};
        r = t[7:0]; c = t[8];
        h = (~x[3] & y[3]) | (y[3] & r[3]) | (r[3] & ~x[3]);
        v = (x[7] != y[7]) && (r[7] != x[7]);
        upd = 8'h3F;
        wr = (op_i != OP_CP) && (op_i != OP_CPC);
      end
      OP_AND: begin r = a_i & b_i; v = 1'b0; upd = 8'h1E; end
      OP_OR:  begin r = a_i | b_i; v = 1'b0; upd = 8'h1E; end
      OP_XOR: begin r = a_i ^ b_i; v = 1'b0; upd = 8'h1E; end
      OP_COM: begin r = ~a_i; c = 1'b1; v = 1'b0; upd = 8'h1F; end
      OP_INC: begin r = a_i + 8'd1; v = (r == 8'h80); upd = 8'h1E; end
      OP_DEC: begin r = a_i - 8'd1; v = (r == 8'h7F); upd = 8'h1E; end
      OP_LSR, OP_ROR, OP_ASR: begin
        r = {(op_i == OP_ROR) ? flags_i[0] : (op_i == OP_ASR) ? a_i[7] : 1'b0, a_i[7:1]};
        c = a_i[0]; v = r[7] ^ a_i[0]; upd = 8'h1F;
      end
      OP_ROL, OP_LSL: begin
        r = {a_i[6:0], (op_i == OP_ROL) & flags_i[0]};
        c = a_i[7]; h = a_i[3]; v = r[7] ^ a_i[7]; upd = 8'h3F;
      end
      OP_SWP: r = {a_i[3:0], a_i[7:4]};
      default: wr = 1'b0;
    endcase
    z = (r == 8'h00) && (!chain || flags_i[1]);
    comp = {flags_i[7:6], h, r[7] ^ v, v, r[7], z, c};
    nf = (comp & upd) | (flags_i & ~upd);
    if (op_i == OP_FST) nf[b_i[2:0]] = 1'b1;
    if (op_i == OP_FCL) nf[b_i[2:0]] = 1'b0;
  end

  assign res_o   = r;
  assign wr_en_o = wr;
  assign flags_o = nf;

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, flags_i})) begin
      if (op_i == OP_SWP)
        p_swap_keeps_flags_r8: assert (flags_o == flags_i);
      if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
        p_logic_v_clear_r3: assert (!flags_o[3] && flags_o[7:5] == flags_i[7:5] && flags_o[0] == flags_i[0]);
      if (op_i == OP_INC || op_i == OP_DEC)
        p_incdec_keeps_c_r5: assert (flags_o[0] == flags_i[0]);
      if (op_i == OP_CP || op_i == OP_CPC)
        p_compare_no_write_r9: assert (!wr_en_o);
      if ((op_i == OP_SBC || op_i == OP_CPC) && !flags_i[1])
        p_zero_chain_r10: assert (!flags_o[1]);
      if (op_i <= OP_ASR || op_i == OP_CP || op_i == OP_CPC || op_i == OP_LSL)
        p_sign_rule_r12: assert (flags_o[4] == (flags_o[2] ^ flags_o[3]));
      if (op_i > OP_LSL)
        p_unused_passive_r12: assert (!wr_en_o && flags_o == flags_i);
    end
  end
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] op;
  logic [7:0] a, b, fl, res, fo;
  logic       wr;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  alu8_flags u_dut (.op_i(op), .a_i(a), .b_i(b), .flags_i(fl),
                    .res_o(res), .wr_en_o(wr), .flags_o(fo));

  function automatic string req_of(int o);
    case (o)
      0,1,2,3: return "R2";
      4,5,6:   return "R3";
      7,8:     return "R4";
      9,10:    return "R5";
      11,12,14: return "R6";
      13,20:   return "R7";
      15:      return "R8";
      16:      return "R9";
      17:      return "R10";
      18,19:   return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [16:0] model(int o, int ai, int bi, logic [7:0] f);
    int r, ci, sa, sb, sr;
    bit c, h, v, n, z, w, ch;
    logic [7:0] upd, nv, out;
    r = ai; c = f[0]; h = f[5]; v = f[3]; w = 1; ch = 0; upd = 8'h00;
    sa = (ai >= 128) ? ai - 256 : ai;
    sb = (bi >= 128) ? bi - 256 : bi;
    case (o)
      0, 1: begin // R2
        ci = (o == 1) ? int'(f[0]) : 0;
        r = ai + bi + ci; c = r > 255; h = (ai % 16 + bi % 16 + ci) > 15;
        sr = sa + sb + ci; v = (sr > 127) || (sr < -128); r = r % 256; upd = 8'h3F;
      end
      2, 3, 16, 17: begin // R2 R9 R10
        ch = (o == 3) || (o == 17);
        ci = ch ? int'(f[0]) : 0;
        r = ai - bi - ci; c = r < 0; h = (ai % 16 - bi % 16 - ci) < 0;
        sr = sa - sb - ci; v = (sr > 127) || (sr < -128); r = (r + 512) % 256;
        upd = 8'h3F; w = (o == 2) || (o == 3);
      end
      4: begin r = ai & bi; v = 0; upd = 8'h1E; end // R3
      5: begin r = ai | bi; v = 0; upd = 8'h1E; end
      6: begin r = ai ^ bi; v = 0; upd = 8'h1E; end
      7: begin r = 255 - ai; c = 1; v = 0; upd = 8'h1F; end // R4
      8: begin r = (256 - ai) % 256; c = ai != 0; h = (ai % 16) != 0; v = ai == 128; upd = 8'h3F; end
      9:  begin r = (ai + 1) % 256; v = ai == 127; upd = 8'h1E; end // R5
      10: begin r = (ai + 255) % 256; v = ai == 128; upd = 8'h1E; end
      11, 12, 14: begin // R6
        r = ai / 2 + ((o == 12 && f[0]) || (o == 14 && ai >= 128) ? 128 : 0);
        c = ai % 2; v = (r >= 128) ^ c; upd = 8'h1F;
      end
      13, 20: begin // R7
        r = (ai * 2) % 256 + ((o == 13 && f[0]) ? 1 : 0);
        c = ai >= 128; h = (ai / 8) % 2; v = (r >= 128) ^ c; upd = 8'h3F;
      end
      15: r = (ai % 16) * 16 + ai / 16; // R8
      18, 19: w = 0; // R11
      default: w = 0; // R12
    endcase
    n = r >= 128;
    z = (r == 0) && (!ch || f[1]);
    nv = {f[7], f[6], h, n ^ v, v, n, z, c};
    out = (nv & upd) | (f & ~upd);
    if (o == 18) out[bi % 8] = 1'b1;
    if (o == 19) out[bi % 8] = 1'b0;
    return {w, r[7:0], out};
  endfunction

  task automatic apply_check(int o, int ai, int bi, logic [7:0] f);
    logic [16:0] e;
    @(posedge clk); #1;
    op = o[4:0]; a = ai[7:0]; b = bi[7:0]; fl = f;
    e = model(o, ai, bi, f);
    @(negedge clk);
    n_checks++;
    if (wr !== e[16] || fo !== e[7:0] || (e[16] && res !== e[15:8])) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h f=%h: got wr=%b res=%h flags=%h, expected wr=%b res=%h flags=%h",
               req_of(o), o, ai, bi, f, wr, res, fo, e[16], e[15:8], e[7:0]);
    end
  endtask

  initial begin
    op = 5'd15; a = 8'h00; b = 8'h00; fl = 8'h00;
    // R1 directed: flag positions and opcode numbers
    apply_check(0, 8'h7F, 8'h01, 8'h00);   // R2 overflow, half carry
    apply_check(0, 8'hFF, 8'h01, 8'h00);   // R2 carry and zero
    apply_check(17, 8'h00, 8'h00, 8'h01);  // R10 borrow with Z clear stays clear
    apply_check(18, 8'h00, 8'h07, 8'h00);  // R11 set I
    apply_check(19, 8'h00, 8'h06, 8'hFF);  // R11 clear T
    apply_check(15, 8'h3C, 8'h00, 8'hFF);  // R8
    apply_check(21, 8'h12, 8'h34, 8'h5A);  // R12 unused
    for (int o = 0; o < 32; o++)
      for (int ai = 0; ai < 256; ai++)
        for (int k = 0; k < 8; k++) begin
          apply_check(o, ai, (k * 37) % 256, 8'h00);
          apply_check(o, ai, (k * 37) % 256, 8'hA3);
        end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R1: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule